// File: doc/BRIEF.md
# Scan Cycle Tracker with Imaging Trigger

This block follows the cycle-timing line of a fast-scan voltammetry recorder. The line is low while a scan runs and high for the rest of the cycle. A typical cycle is about 100 ms long and holds a scan window of about 10 ms. The block learns the timing from the line alone; no one enters a period. It brings the line into its clock domain and counts clock ticks. From the counts it reports two values: the cycle period (from one scan start to the next) and the window width (from a scan start to the scan end that follows).

A phase counter restarts at every scan start, and a window flag is high while a scan is in progress. Other logic can use these to schedule events around the scans. The measurement is marked valid once two consecutive complete cycles agree. If the line goes quiet for too long, the valid mark is dropped and the tracker starts hunting again.

When the trigger is enabled, the block sends a short pulse as each scan window ends. An external imaging scanner can use it to fire between scans.

The controller has three states:
- `ST_SEEK` waits for a scan start and ignores scan ends.
- `ST_WINDOW` is a scan in progress.
- `ST_GAP` is the time between a scan end and the next scan start.

It has five transitions:
- SEEK→WINDOW on a falling edge.
- WINDOW→GAP on a rising edge. This is the window end, and the trigger may fire here.
- GAP→WINDOW on a falling edge. This closes a cycle and updates the measurement.
- WINDOW→SEEK on a timeout.
- GAP→SEEK on a timeout.

Top module: `scan_tracker`

## Requirements
- R1: `scan_in` passes through a two-stage synchroniser, followed by edge detection. `window_o` rises on the third clock edge at which `scan_in` is low after a high level, and falls on the third clock edge at which it is high again.
- R2: When a cycle closes (a falling edge in ST_GAP), `period_o` becomes the number of clock cycles between that falling edge of `scan_in` and the previous one.
- R3: When a cycle closes, `width_o` becomes the number of clock cycles for which `scan_in` was low in that cycle.
- R4: `phase_o` is 0 on the clock on which `window_o` rises. It then increases by 1 on every clock and saturates at all-ones.
- R5: `valid_o` is updated only when a cycle closes. It becomes 1 only if the cycle just closed and the one closed before it differ by at most TOL ticks in period and by at most TOL ticks in width. The first cycle closed after reset or after a timeout always leaves `valid_o` at 0.
- R6: A timeout occurs when a stored measurement exists and `phase_o` reaches twice `period_o` before the next falling edge. A timeout clears `valid_o`, returns the controller to ST_SEEK (`window_o` low) and discards the stored cycle.
- R7: When `trig_en` is 1 at a window end, `trig_o` goes high on the same clock on which `window_o` falls. It stays high for exactly TRIG_LEN clocks.
- R8: When `trig_en` is 0 at a window end, no pulse is produced for that window.
- R9: While `rst_n` is low, every output is 0.
- R10: In ST_SEEK a rising edge of `scan_in` has no effect. After reset, with `scan_in` held low and then raised, `window_o`, `trig_o` and `width_o` all stay 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scan_in | input | 1 | Raw cycle-timing line; low while a scan runs |
| trig_en | input | 1 | Enables the end-of-window trigger |
| period_o | output | CNT_W | Last measured cycle period in ticks |
| width_o | output | CNT_W | Last measured window width in ticks |
| phase_o | output | CNT_W | Ticks since the latest scan start |
| valid_o | output | 1 | Two consecutive cycles agreed |
| window_o | output | 1 | Scan window in progress |
| trig_o | output | 1 | Trigger pulse after each window end |

## Verification
The bench targets the boundaries where an off-by-one shows up:
- A wrong synchroniser depth or a wrong count origin would shift `window_o`, `phase_o` or the stored width by one tick.
- The valid rule is probed with a period one tick off, which must stay valid, and with larger period and width jumps, which must drop valid for exactly one cycle. A design that compared against the wrong cycle would mark one of these wrongly.
- A cycle stretched past twice the period must drop back to hunting. A tracker without the timeout, or one that kept its stored cycle, would report valid one cycle too early afterwards.
- A rising edge seen straight out of reset must not produce a trigger or a width, and a disabled window must produce no pulse.

// File: rtl/scan_trk_pkg.sv
package scan_trk_pkg;
    typedef enum logic [1:0] {
        ST_SEEK   = 2'd0,
        ST_WINDOW = 2'd1,
        ST_GAP    = 2'd2
    } trk_state_e;
endpackage

// File: rtl/scan_edge_sync.sv
module scan_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic fall_o,
    output logic rise_o
);
    logic [STAGES-1:0] chain_q;
    logic              last_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= raw_i;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], raw_i};
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= chain_q[STAGES-1];
    end

    assign fall_o = last_q & ~chain_q[STAGES-1];
    assign rise_o = ~last_q & chain_q[STAGES-1];
endmodule

// File: rtl/scan_meas_fsm.sv
module scan_meas_fsm
    import scan_trk_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int TOL   = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fall_i,
    input  logic             rise_i,
    output logic [CNT_W-1:0] period_o,
    output logic [CNT_W-1:0] width_o,
    output logic [CNT_W-1:0] phase_o,
    output logic             valid_o,
    output logic             window_o,
    output logic             win_end_o
);
    localparam logic [CNT_W-1:0] TOL_V  = CNT_W'(TOL);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    trk_state_e       state_q, state_d;
    logic [CNT_W-1:0] phase_q, period_q, width_q, width_cur_q, meas;
    logic             valid_q, have_ref_q;
    logic             timeout, close_evt, end_evt, drop_evt;

    function automatic logic near(input logic [CNT_W-1:0] a, input logic [CNT_W-1:0] b);
        logic [CNT_W-1:0] d;
        d = (a > b) ? (a - b) : (b - a);
        return d <= TOL_V;
    endfunction

    assign meas    = (phase_q == CNT_MAX) ? CNT_MAX : phase_q + 1'b1;
    assign timeout = have_ref_q && ({1'b0, phase_q} >= {period_q, 1'b0});

    // next state and event decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SEEK:   if (fall_i) state_d = ST_WINDOW;
            ST_WINDOW: if (rise_i) state_d = ST_GAP;
                       else if (timeout) state_d = ST_SEEK;
            ST_GAP:    if (fall_i) state_d = ST_WINDOW;
                       else if (timeout) state_d = ST_SEEK;
            default:   state_d = ST_SEEK;
        endcase
    end

    assign close_evt = (state_q == ST_GAP) && fall_i;
    assign end_evt   = (state_q == ST_WINDOW) && rise_i;
    assign drop_evt  = (state_d == ST_SEEK) && (state_q != ST_SEEK);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_SEEK;
        else        state_q <= state_d;
    end

    // measurement registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q     <= '0;
            period_q    <= '0;
            width_q     <= '0;
            width_cur_q <= '0;
            valid_q     <= 1'b0;
            have_ref_q  <= 1'b0;
        end else begin
            phase_q <= fall_i ? '0 : meas;
            if (end_evt) width_cur_q <= meas;
            if (close_evt) begin
                period_q   <= meas;
                width_q    <= width_cur_q;
                valid_q    <= have_ref_q && near(meas, period_q) && near(width_cur_q, width_q);
                have_ref_q <= 1'b1;
            end else if (drop_evt) begin
                valid_q    <= 1'b0;
                have_ref_q <= 1'b0;
            end
        end
    end

    assign period_o  = period_q;
    assign width_o   = width_q;
    assign phase_o   = phase_q;
    assign valid_o   = valid_q;
    assign window_o  = (state_q == ST_WINDOW);
    assign win_end_o = end_evt;
endmodule

// File: rtl/scan_trig_pulse.sv
module scan_trig_pulse #(
    parameter int TRIG_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire_i,
    output logic trig_o
);
    localparam int TW = $clog2(TRIG_LEN + 1);

    logic [TW-1:0] left_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              left_q <= '0;
        else if (fire_i)         left_q <= TW'(TRIG_LEN);
        else if (left_q != '0)   left_q <= left_q - 1'b1;
    end

    assign trig_o = (left_q != '0);
endmodule

// File: rtl/scan_tracker.sv
module scan_tracker #(
    parameter int CNT_W       = 16,
    parameter int TOL         = 1,
    parameter int TRIG_LEN    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scan_in,
    input  logic             trig_en,
    output logic [CNT_W-1:0] period_o,
    output logic [CNT_W-1:0] width_o,
    output logic [CNT_W-1:0] phase_o,
    output logic             valid_o,
    output logic             window_o,
    output logic             trig_o
);
    logic fall, rise, win_end;

    scan_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (scan_in),
        .fall_o (fall),
        .rise_o (rise)
    );

    scan_meas_fsm #(.CNT_W(CNT_W), .TOL(TOL)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .fall_i    (fall),
        .rise_i    (rise),
        .period_o  (period_o),
        .width_o   (width_o),
        .phase_o   (phase_o),
        .valid_o   (valid_o),
        .window_o  (window_o),
        .win_end_o (win_end)
    );

    scan_trig_pulse #(.TRIG_LEN(TRIG_LEN)) u_trig (
        .clk    (clk),
        .rst_n  (rst_n),
        .fire_i (win_end & trig_en),
        .trig_o (trig_o)
    );
endmodule

// File: rtl/scan_trk_chk.sv
module scan_trk_chk #(
    parameter int CNT_W    = 16,
    parameter int TRIG_LEN = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             trig_en,
    input logic [CNT_W-1:0] period_o,
    input logic [CNT_W-1:0] phase_o,
    input logic             valid_o,
    input logic             window_o,
    input logic             trig_o
);
    int run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      run_q <= 0;
        else if (trig_o) run_q <= run_q + 1;
        else             run_q <= 0;
    end

    assert_trig_at_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trig_o) |-> ($past(window_o) && !window_o));

    assert_trig_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
        trig_o |-> (run_q < TRIG_LEN));

    assert_trig_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(trig_o) |-> (run_q == TRIG_LEN));

    assert_trig_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trig_o) |-> $past(trig_en));

    assert_phase_origin_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(window_o) |-> (phase_o == '0));

    assert_phase_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (window_o && $past(window_o)) |-> ((phase_o == $past(phase_o) + 1'b1) || (&$past(phase_o))));

    assert_valid_at_close_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid_o) |-> $rose(window_o));

    assert_valid_period_R5: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (period_o != '0));
endmodule

bind scan_tracker scan_trk_chk #(.CNT_W(CNT_W), .TRIG_LEN(TRIG_LEN)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .trig_en  (trig_en),
    .period_o (period_o),
    .phase_o  (phase_o),
    .valid_o  (valid_o),
    .window_o (window_o),
    .trig_o   (trig_o)
);

// File: tb/sim_scan_tracker.sv
module sim_scan_tracker;
    localparam int CNT_W = 16;
    localparam int TOL = 1;
    localparam int TRIG_LEN = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scan_in = 1'b0;
    logic trig_en = 1'b1;
    logic [CNT_W-1:0] period_o, width_o, phase_o;
    logic valid_o, window_o, trig_o;

    scan_tracker #(.CNT_W(CNT_W), .TOL(TOL), .TRIG_LEN(TRIG_LEN), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .scan_in(scan_in), .trig_en(trig_en),
        .period_o(period_o), .width_o(width_o), .phase_o(phase_o),
        .valid_o(valid_o), .window_o(window_o), .trig_o(trig_o)
    );

    always #2 clk = ~clk;

    typedef struct { int p; int w; bit v; } exp_t;
    exp_t exp_q[$];

    int n_chk = 0, n_bad = 0;
    int trig_seen = 0, trig_exp = 0, run = 0;
    bit win_prev = 0, trig_prev = 0, done = 0;

    // bench-side model state
    bit have_last = 0, ref_ok = 0;
    int last_p = 0, last_w = 0, ref_p = 0, ref_w = 0, out_p = 0, out_w = 0;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    function automatic bit close_enough(input int a, input int b);
        return ((a > b) ? a - b : b - a) <= TOL;
    endfunction

    // driver: one cycle of P clocks, low for W clocks
    task automatic drive_cycle(input int p, input int w, input bit en);
        exp_t e;
        bit vv;
        vv = 0;
        if (have_last) begin
            vv = ref_ok && close_enough(last_p, ref_p) && close_enough(last_w, ref_w);
            out_p = last_p; out_w = last_w;
            ref_p = last_p; ref_w = last_w; ref_ok = 1;
        end
        e.p = out_p; e.w = out_w; e.v = vv;
        exp_q.push_back(e);
        if (en) trig_exp++;
        scan_in = 1'b0;
        trig_en = en;
        repeat (2) @(negedge clk);
        chk(window_o == 1'b0, "R1", window_o, 0);
        @(negedge clk);
        chk(window_o == 1'b1, "R1", window_o, 1);
        repeat (w - 3) @(negedge clk);
        chk(phase_o == CNT_W'(w - 3), "R4", phase_o, w - 3);
        scan_in = 1'b1;
        repeat (p - w) @(negedge clk);
        if (ref_ok && (p - 1 > 2 * out_p)) begin
            ref_ok = 0; have_last = 0;
        end else begin
            have_last = 1; last_p = p; last_w = w;
        end
    endtask

    // monitor: compares the scoreboard against results as they appear
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (window_o && !win_prev) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R2", 0, 1);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(period_o == CNT_W'(e.p), "R2", period_o, e.p);
                    chk(width_o == CNT_W'(e.w), "R3", width_o, e.w);
                    chk(valid_o == e.v, "R5", valid_o, e.v);
                    chk(phase_o == '0, "R4", phase_o, 0);
                end
            end
            if (trig_o && !trig_prev) begin
                trig_seen++;
                chk(!window_o && win_prev, "R7", window_o, 0);
                run = 1;
            end else if (trig_o) begin
                run++;
            end else if (trig_prev) begin
                chk(run == TRIG_LEN, "R7", run, TRIG_LEN);
            end
            win_prev = window_o;
            trig_prev = trig_o;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R9: reset state
        repeat (3) @(negedge clk);
        chk(period_o == '0 && width_o == '0 && phase_o == '0, "R9", period_o, 0);
        chk(!valid_o && !window_o && !trig_o, "R9", {valid_o, window_o, trig_o}, 0);
        rst_n = 1'b1;

        // R10: rising edge while seeking is ignored
        repeat (10) @(negedge clk);
        scan_in = 1'b1;
        repeat (20) @(negedge clk);
        chk(window_o == 1'b0, "R10", window_o, 0);
        chk(trig_seen == 0, "R10", trig_seen, 0);
        chk(width_o == '0, "R10", width_o, 0);

        // steady cycles, tolerance, disable, period and width jumps
        drive_cycle(40, 8, 1);
        drive_cycle(40, 8, 1);
        drive_cycle(40, 8, 1);
        drive_cycle(41, 8, 1);
        drive_cycle(40, 8, 0);   // R8: no pulse for this window
        chk(trig_seen == trig_exp, "R8", trig_seen, trig_exp);
        drive_cycle(52, 8, 1);
        drive_cycle(52, 8, 1);
        drive_cycle(52, 12, 1);
        drive_cycle(52, 12, 1);
        drive_cycle(52, 12, 1);

        // R6: stretched cycle causes a timeout
        drive_cycle(200, 12, 1);
        chk(valid_o == 1'b0, "R6", valid_o, 0);
        chk(window_o == 1'b0, "R6", window_o, 0);
        drive_cycle(52, 12, 1);
        drive_cycle(52, 12, 1);
        drive_cycle(52, 12, 1);
        drive_cycle(30, 5, 1);

        chk(exp_q.size() == 0, "R2", exp_q.size(), 0);
        chk(trig_seen == trig_exp, "R7", trig_seen, trig_exp);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule